// File: doc/BRIEF.md
# Timestamped Cluster Sample Recorder

This block captures a 16-bit logic input at a programmable fraction of its base clock and stores what it sees in a compact, change-driven form. Samples are grouped into clusters. A cluster is one timestamp word followed by seven consecutive samples. The timestamp counts sample ticks, so when one cluster's timestamp lies well past the end of the previous cluster, the reader knows the input held its last recorded value over the gap. The recorder opens a new cluster only when it has to: on the first tick after arming, when the input differs from the last recorded value, when a trigger is seen, or when the timestamp gap would otherwise become too large to represent.

Each cluster is written as one wide word into a line-organised memory. A line holds a fixed number of clusters. The write position is exported as a packed line/event value, so a host can find how far the capture got, including the fill level of a final partial cluster. A trigger input freezes the position of the event where it was first seen. Capture ends on a stop request, or by itself when the line field reaches its all-ones value.

Top module: `ts_cluster_recorder`

## Requirements
- R1: After `arm`, the recorder takes one sample tick every `F+1` clock cycles, where `F` is the `div_frac` value (0 to 255) captured in the arm cycle. The first tick falls `F+1` cycles after the arm edge.
- R2: A cluster word holds the timestamp, zero-extended, in bits [15:0], and sample k (k = 0..6) in bits [16k+31:16k+16]. Sample k belongs to timestamp+k. In a partial cluster, each slot that was never filled repeats the last sample recorded in that cluster.
- R3: The timestamp of tick n after arm (n counted from 0) is n modulo 2^TS_W.
- R4: A tick with no cluster open is recorded, and opens a cluster, only in these cases: it is the first tick after arm; the input differs from the last recorded sample; a trigger is taken on it; or its timestamp equals the open timestamp of the previous cluster minus one, modulo 2^TS_W. Any other tick with no cluster open is dropped. A tick with a cluster open is always recorded.
- R5: A completed cluster is written at address {line, cluster index}, with the cluster index in the low CLU_W bits. `mem_we` is high for exactly the one cycle after the tick that filled the seventh slot.
- R6: `stop_pos` equals {line, event}, zero-extended to 24 bits. Here event = 7 × cluster index + number of filled slots in the open cluster, held in the low EVT_W bits (9 by default).
- R7: A `stop` during capture ends capture. If a cluster is partly filled, it is written at its own address in the next cycle. A tick in the same cycle as `stop` is ignored. `stop_pos` keeps the partial fill level afterwards.
- R8: When a completed cluster advances the line field to 2^LINE_W−1, capture ends and `mem_full` goes high. Later ticks, triggers and stop requests write nothing and leave the position unchanged.
- R9: The first tick that sees `trig_hit` high during capture is always recorded. That tick latches `trig_pos` as the position value of its own event and sets `trig_fired`. Both then stay constant until the next `arm`, whatever `trig_hit` does.
- R10: After reset the block is idle with all outputs zero. `arm` clears the position, `trig_pos`, `trig_fired` and `mem_full`, and starts capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start a new capture (one-cycle pulse) |
| stop | input | 1 | End the current capture (one-cycle pulse) |
| div_frac | input | DIV_W | Tick period minus one, captured at arm |
| sample_in | input | SMP_W | Logic input being recorded |
| trig_hit | input | 1 | Trigger condition, evaluated externally |
| mem_we | output | 1 | Cluster write strobe |
| mem_addr | output | LINE_W+CLU_W | Cluster address {line, cluster} |
| mem_wdata | output | 8*SMP_W | Cluster word: timestamp and seven samples |
| stop_pos | output | POS_W | Current write position {line, event} |
| trig_pos | output | POS_W | Position latched at the trigger |
| trig_fired | output | 1 | Trigger position has been latched |
| capturing | output | 1 | Capture in progress |
| mem_full | output | 1 | Capture ended because the memory is full |

## Verification
The bench runs a small configuration: 8-bit timestamps, four clusters per line and a 2-bit line field. This lets it reach timestamp wrap and memory full quickly. It sweeps the divider and times the first cluster write, so a tick period off by one cycle shows up as a write in the wrong cycle. It also drives long constant runs. A recorder that skipped the forced cluster would leave timestamp gaps of a full wrap or more. A recorder that opened clusters on every tick would write extra words. It stops a capture on the same edge as a tick, and it also lands a trigger inside a constant run and repeats the trigger. Each of these errors changes `stop_pos`, `trig_pos` or the stored words: accepting the late tick, failing to force a cluster at the trigger, or re-latching on a later hit. Finally it fills the memory and checks that capture ends exactly at the last line boundary.

// File: rtl/tscr_pkg.sv
package tscr_pkg;
    // samples carried by one cluster after its timestamp word
    localparam int EV_PER_CLU = 7;
    // words in one cluster: timestamp plus samples
    localparam int WORDS_PER_CLU = EV_PER_CLU + 1;
    // width of the in-cluster fill counter
    localparam int SLOT_W = 3;
endpackage

// File: rtl/tscr_divider.sv
module tscr_divider #(
    parameter int DIV_W = 8,
    parameter int TS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] frac,
    output logic             tick,
    output logic [TS_W-1:0]  ts
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [TS_W-1:0]  stamp;
    } div_t;

    div_t div_q, div_d;

    always_comb begin
        div_d = div_q;
        tick  = run && (div_q.cnt == frac);
        if (restart) begin
            div_d.cnt   = '0;
            div_d.stamp = '0;
        end else if (tick) begin
            div_d.cnt   = '0;
            div_d.stamp = div_q.stamp + 1'b1;
        end else if (run) begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign ts = div_q.stamp;

    // R1
    div_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (div_q.cnt == '0));

    // R3
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (div_q.stamp == TS_W'($past(div_q.stamp) + 1'b1)));
endmodule

// File: rtl/tscr_cluster_buf.sv
module tscr_cluster_buf #(
    parameter int SMP_W = 16,
    parameter int TS_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept,
    input  logic                        open_new,
    input  logic [tscr_pkg::SLOT_W-1:0] slot,
    input  logic [TS_W-1:0]             ts,
    input  logic [SMP_W-1:0]            sample,
    output logic [tscr_pkg::WORDS_PER_CLU*SMP_W-1:0] word
);
    localparam int NEV = tscr_pkg::EV_PER_CLU;

    typedef struct packed {
        logic [NEV-1:0][SMP_W-1:0] slots;
        logic [SMP_W-1:0]          stamp;
    } clu_t;

    clu_t clu_q, clu_d;
    logic [NEV-1:0] fill;

    // a sample lands in its own slot and pre-fills every later one
    generate
        for (genvar k = 0; k < NEV; k++) begin : g_fill
            assign fill[k] = accept && (slot <= tscr_pkg::SLOT_W'(k));
        end
    endgenerate

    always_comb begin
        clu_d = clu_q;
        if (accept && open_new) clu_d.stamp = SMP_W'(ts);
        for (int k = 0; k < NEV; k++) begin
            if (fill[k]) clu_d.slots[k] = sample;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clu_q <= '0;
        else        clu_q <= clu_d;
    end

    assign word = clu_q;

    // R2
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && open_new) |=> $stable(clu_q.stamp));
endmodule

// File: rtl/tscr_position.sv
module tscr_position #(
    parameter int CLU_PER_LINE = 64,
    parameter int LINE_W       = 15,
    localparam int CLU_W       = $clog2(CLU_PER_LINE)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        restart,
    input  logic                        accept,
    output logic [tscr_pkg::SLOT_W-1:0] slot,
    output logic [CLU_W-1:0]            clu,
    output logic [LINE_W-1:0]           line,
    output logic                        cl_done
);
    localparam int SW = tscr_pkg::SLOT_W;

    typedef struct packed {
        logic [SW-1:0]     slot;
        logic [CLU_W-1:0]  clu;
        logic [LINE_W-1:0] line;
    } pos_t;

    pos_t pos_q, pos_d;

    always_comb begin
        pos_d   = pos_q;
        cl_done = accept && (pos_q.slot == SW'(tscr_pkg::EV_PER_CLU - 1));
        if (restart) begin
            pos_d = '0;
        end else if (cl_done) begin
            pos_d.slot = '0;
            if (pos_q.clu == CLU_W'(CLU_PER_LINE - 1)) begin
                pos_d.clu  = '0;
                pos_d.line = pos_q.line + 1'b1;
            end else begin
                pos_d.clu = pos_q.clu + 1'b1;
            end
        end else if (accept) begin
            pos_d.slot = pos_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign slot = pos_q.slot;
    assign clu  = pos_q.clu;
    assign line = pos_q.line;

    // R6
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.slot < SW'(tscr_pkg::EV_PER_CLU));
endmodule

// File: rtl/ts_cluster_recorder.sv
module ts_cluster_recorder #(
    parameter int SMP_W        = 16,
    parameter int DIV_W        = 8,
    parameter int TS_W         = 16,
    parameter int CLU_PER_LINE = 64,
    parameter int LINE_W       = 15,
    parameter int POS_W        = 24,
    localparam int CLU_W       = $clog2(CLU_PER_LINE),
    localparam int EVT_W       = $clog2(CLU_PER_LINE * tscr_pkg::EV_PER_CLU),
    localparam int ADDR_W      = LINE_W + CLU_W,
    localparam int WORD_W      = tscr_pkg::WORDS_PER_CLU * SMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              stop,
    input  logic [DIV_W-1:0]  div_frac,
    input  logic [SMP_W-1:0]  sample_in,
    input  logic              trig_hit,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [POS_W-1:0]  stop_pos,
    output logic [POS_W-1:0]  trig_pos,
    output logic              trig_fired,
    output logic              capturing,
    output logic              mem_full
);
    localparam int SW        = tscr_pkg::SLOT_W;
    localparam int LINE_LAST = (1 << LINE_W) - 1;

    typedef struct packed {
        logic              capt;
        logic              full;
        logic              fired;
        logic              first;
        logic [DIV_W-1:0]  frac;
        logic [SMP_W-1:0]  held;
        logic [TS_W-1:0]   base;
        logic [POS_W-1:0]  tpos;
        logic              we;
        logic [ADDR_W-1:0] waddr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              tick;
    logic [TS_W-1:0]   ts;
    logic [SW-1:0]     slot;
    logic [CLU_W-1:0]  clu;
    logic [LINE_W-1:0] line;
    logic              cl_done;
    logic              accept;
    logic              open_new;
    logic              is_open;
    logic              trig_evt;
    logic              wrap_due;
    logic              want_open;
    logic              stop_now;
    logic              full_hit;
    logic [TS_W-1:0]   base_m1;
    logic [EVT_W-1:0]  evt_now;
    logic [POS_W-1:0]  pos_now;

    tscr_divider #(.DIV_W(DIV_W), .TS_W(TS_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm),
        .run     (ctl_q.capt),
        .frac    (ctl_q.frac),
        .tick    (tick),
        .ts      (ts)
    );

    tscr_position #(.CLU_PER_LINE(CLU_PER_LINE), .LINE_W(LINE_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm),
        .accept  (accept),
        .slot    (slot),
        .clu     (clu),
        .line    (line),
        .cl_done (cl_done)
    );

    tscr_cluster_buf #(.SMP_W(SMP_W), .TS_W(TS_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .open_new (open_new),
        .slot     (slot),
        .ts       (ts),
        .sample   (sample_in),
        .word     (mem_wdata)
    );

    always_comb begin
        is_open   = (slot != '0);
        base_m1   = ctl_q.base - 1'b1;
        wrap_due  = (ts == base_m1);
        trig_evt  = trig_hit && !ctl_q.fired;
        want_open = ctl_q.first || (sample_in != ctl_q.held) || trig_evt || wrap_due;
        stop_now  = ctl_q.capt && stop && !arm;
        accept    = tick && !stop && !arm && (is_open || want_open);
        open_new  = accept && !is_open;
        full_hit  = cl_done && (clu == CLU_W'(CLU_PER_LINE - 1))
                    && (line == LINE_W'(LINE_LAST - 1));
        evt_now   = EVT_W'(clu) * EVT_W'(tscr_pkg::EV_PER_CLU) + EVT_W'(slot);
        pos_now   = POS_W'({line, evt_now});
    end

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.we = 1'b0;
        if (arm) begin
            ctl_d.capt  = 1'b1;
            ctl_d.full  = 1'b0;
            ctl_d.fired = 1'b0;
            ctl_d.first = 1'b1;
            ctl_d.frac  = div_frac;
            ctl_d.base  = '0;
            ctl_d.tpos  = '0;
        end else begin
            if (stop_now) begin
                ctl_d.capt = 1'b0;
                if (is_open) begin
                    ctl_d.we    = 1'b1;
                    ctl_d.waddr = {line, clu};
                end
            end
            if (accept) begin
                ctl_d.held  = sample_in;
                ctl_d.first = 1'b0;
                if (open_new) ctl_d.base = ts;
                if (trig_evt) begin
                    ctl_d.fired = 1'b1;
                    ctl_d.tpos  = pos_now;
                end
                if (cl_done) begin
                    ctl_d.we    = 1'b1;
                    ctl_d.waddr = {line, clu};
                end
                if (full_hit) begin
                    ctl_d.capt = 1'b0;
                    ctl_d.full = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mem_we     = ctl_q.we;
    assign mem_addr   = ctl_q.waddr;
    assign stop_pos   = pos_now;
    assign trig_pos   = ctl_q.tpos;
    assign trig_fired = ctl_q.fired;
    assign capturing  = ctl_q.capt;
    assign mem_full   = ctl_q.full;

    // R8
    full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_full |-> !capturing);

    // R9
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_fired && !arm) |=> (trig_fired && $stable(trig_pos)));

    // R7
    stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing && stop && !arm && slot != '0) |=> (mem_we && !capturing));

    // R5
    done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cl_done |=> mem_we);
endmodule

// File: tb/tb_ts_cluster_recorder.sv
`timescale 1ns/1ps
module tb_ts_cluster_recorder;
    localparam int SW = 16, DW = 8, TW = 8, CPL = 4, LW = 2, PW = 24;
    localparam int AW = 4, WW = 128, EVSH = 32, LLAST = 3;

    logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, stop = 1'b0, trig_hit = 1'b0;
    logic [DW-1:0] div_frac = '0;
    logic [SW-1:0] sample_in = '0;
    logic          mem_we, trig_fired, capturing, mem_full;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic [PW-1:0] stop_pos, trig_pos;

    ts_cluster_recorder #(.SMP_W(SW), .DIV_W(DW), .TS_W(TW), .CLU_PER_LINE(CPL),
                          .LINE_W(LW), .POS_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .div_frac(div_frac),
        .sample_in(sample_in), .trig_hit(trig_hit), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .stop_pos(stop_pos),
        .trig_pos(trig_pos), .trig_fired(trig_fired), .capturing(capturing),
        .mem_full(mem_full));

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    int vectors = 0, fails = 0;
    int arm_cyc;
    logic [SW-1:0] smp [0:1023];
    int trig_a, trig_b;

    logic [AW-1:0] got_addr [0:63];
    logic [WW-1:0] got_data [0:63];
    int            got_cyc  [0:63];
    int            got_n = 0;

    logic [AW-1:0] exp_addr [0:63];
    logic [WW-1:0] exp_data [0:63];
    int exp_n, exp_spos, exp_tpos, exp_fired, exp_full;

    always @(negedge clk) begin
        if (mem_we === 1'b1) begin
            if (got_n < 64) begin
                got_addr[got_n] = mem_addr;
                got_data[got_n] = mem_wdata;
                got_cyc[got_n]  = cyc;
            end
            got_n = got_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model(input int n);
        int slot = 0, clu = 0, line = 0, base = 0, ts;
        int first = 1, fired = 0, full = 0;
        logic [SW-1:0] held = '0;
        logic [WW-1:0] w = '0;
        bit tg, op;
        exp_n = 0; exp_tpos = 0;
        for (int i = 0; i < n; i++) begin
            if (full) break;
            ts = i % 256;
            tg = (i >= trig_a) && (i <= trig_b) && !fired;
            op = (slot != 0);
            if (op || first || smp[i] != held || tg || ts == (base + 255) % 256) begin
                if (!op) begin base = ts; w[15:0] = 16'(ts); end
                for (int j = slot; j < 7; j++) w[16*(j+1) +: 16] = smp[i];
                if (tg) begin exp_tpos = line * EVSH + clu * 7 + slot; fired = 1; end
                held = smp[i]; first = 0; slot++;
                if (slot == 7) begin
                    exp_addr[exp_n] = AW'(line * CPL + clu); exp_data[exp_n] = w; exp_n++;
                    slot = 0; clu++;
                    if (clu == CPL) begin clu = 0; line++; if (line == LLAST) full = 1; end
                end
            end
        end
        if (!full && slot != 0) begin
            exp_addr[exp_n] = AW'(line * CPL + clu); exp_data[exp_n] = w; exp_n++;
        end
        exp_spos = line * EVSH + clu * 7 + slot;
        exp_fired = fired; exp_full = full;
    endtask

    // arm, drive n ticks, stop, then compare everything against the model
    task automatic run(input string nm, input int frac, input int n, input bit tchk);
        @(posedge clk); got_n = 0;
        @(negedge clk); arm = 1'b1; div_frac = DW'(frac);
        @(negedge clk); arm = 1'b0; arm_cyc = cyc;
        // R10: arm clears position, trigger and full state
        chk({nm, " R10 stop_pos after arm"}, WW'(stop_pos), 0);
        chk({nm, " R10 flags after arm"}, WW'({trig_fired, mem_full, capturing}), 1);
        for (int i = 0; i < n; i++) begin
            sample_in = smp[i];
            trig_hit  = (i >= trig_a) && (i <= trig_b);
            repeat (frac + 1) @(posedge clk);
            @(negedge clk);
        end
        trig_hit = 1'b0;
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (4) @(negedge clk);
        model(n);
        // R5 R2 R4: write count, addresses and cluster words
        chk({nm, " R5 write count"}, WW'(got_n), WW'(exp_n));
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            chk($sformatf("%s R5 addr %0d", nm, k), WW'(got_addr[k]), WW'(exp_addr[k]));
            chk($sformatf("%s R2 R4 word %0d", nm, k), got_data[k], exp_data[k]);
        end
        // R1: first completed cluster appears 7 tick periods after arm
        if (tchk && got_n > 0)
            chk($sformatf("%s R1 first write cycle frac %0d", nm, frac),
                WW'(got_cyc[0] - arm_cyc), WW'(7 * (frac + 1)));
        chk({nm, " R6 R7 stop_pos"}, WW'(stop_pos), WW'(exp_spos));
        chk({nm, " R9 trig_pos"}, WW'(trig_pos), WW'(exp_tpos));
        chk({nm, " R9 trig_fired"}, WW'(trig_fired), WW'(exp_fired));
        chk({nm, " R8 mem_full"}, WW'(mem_full), WW'(exp_full));
        chk({nm, " R7 capture ended"}, WW'(capturing), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        trig_a = -1; trig_b = -1;
        repeat (3) @(negedge clk);
        // R10: idle after reset
        chk("R10 reset outputs", WW'({mem_we, trig_fired, capturing, mem_full}), 0);
        chk("R10 reset stop_pos", WW'(stop_pos), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3: divider sweep, every tick recorded, timestamps from 0
        for (int i = 0; i < 1024; i++) smp[i] = SW'(16'h3c00 + i);
        for (int f = 0; f < 16; f++) run("sweep", f, 7, 1'b1);
        run("sweep", 63, 7, 1'b1);
        run("sweep", 255, 7, 1'b1);

        // R6 R7: partial last cluster, stop coincides with a tick at frac 0
        for (int i = 0; i < 1024; i++) smp[i] = SW'(i * 16'h1111 + 3);
        run("partial", 0, 20, 1'b0);

        // R4 R9: runs of held values, trigger inside a run and repeated
        for (int i = 0; i < 1024; i++) smp[i] = SW'(16'h1000 + (i / 5) % 3);
        trig_a = 12; trig_b = 15;
        run("runs", 2, 60, 1'b0);
        trig_a = 31; trig_b = 31;
        run("runs_late", 0, 45, 1'b0);

        // R3 R4: constant input, clusters forced by timestamp wrap
        for (int i = 0; i < 1024; i++) smp[i] = 16'ha5a5;
        trig_a = -1; trig_b = -1;
        run("wrap", 0, 600, 1'b0);

        // R8: fill the memory, trigger arrives after the end
        for (int i = 0; i < 1024; i++) smp[i] = SW'(16'h7000 + i);
        trig_a = 90; trig_b = 95;
        run("full", 0, 100, 1'b0);

        // R10: re-arm after full starts clean
        trig_a = 2; trig_b = 2;
        run("rearm", 1, 9, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule